// File: doc/BRIEF.md
# Uncached Request Bridge from TileLink A/D to AXI4

This block sits between a TileLink Uncached requester and an AXI4 memory port. Read requests (Get) and write requests (PutFull, PutPartial) arrive one beat at a time on the A channel. Every address request goes into one small shared queue, and each entry records whether it is a write. The head of that queue is offered to AR or to AW according to that record. The bytes of a write go straight to the W channel. A multi-beat write sends its address once but sends data on every beat.

On the return path, AXI read data (R) and write responses (B) share the single TileLink D channel. R has priority. A write response that has waited through seven consecutive cycles without a grant takes the next turn. A read burst that has started keeps the D channel until its final beat. A stall input freezes request intake without disturbing entries that are already queued.

Top module: `tl2axi_bridge`

## Requirements
- R1: A Get (A opcode 4) is accepted whenever the address queue has room. It produces one AR request with `arId` equal to the source, the same address, `arLen` equal to the beat count minus one, and `arSize` equal to the request size capped at the bus width. AR stays asserted with a stable address until `arReady`.
- R2: A PutFull (opcode 0) or PutPartial (opcode 1) produces its address on AW only, never on AR. The queue head leaves on `awReady` for writes and on `arReady` for reads, and entries leave in arrival order.
- R3: A Put of 2^size bytes on a bus of B bytes uses max(1, 2^size/B) beats. AW is issued once, with that count minus one as its length. Each beat drives W with the A data and mask unchanged, and `wLast` is high on the final beat only.
- R4: `wValid` rises only for a valid Put beat when the address has already been sent or the queue has room. A Put beat is accepted only when W is also ready. While W is not ready, neither the beat nor its address is taken.
- R5: The queue holds two entries. When both are occupied, `aReady` stays low and no entry is lost or overwritten.
- R6: While `stall` is high, `aReady` is low and nothing enters the queue.
- R7: R takes the D channel over B unless B has waited seven cycles. A granted R beat appears on D with opcode 1 (AccessAckData), the R id as source, and the R data. `dDenied` is high when `rResp` is not 0.
- R8: A granted B appears on D with opcode 0 (AccessAck), the B id as source, and data 0. `dDenied` is high when `bResp` is not 0.
- R9: The B wait count rises each cycle that B is valid but not granted, and it stops rising at 7. When the count is 7, B wins over a valid R. The count clears when B is granted.
- R10: After a granted R beat with `rLast` low, B is not granted until the R beat marked last has been granted, even while R is idle.
- R11: After reset, AR, AW, W and D valid are low, and `aReady` is high for a Get that is not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes request intake |
| aValid | input | 1 | A beat valid |
| aReady | output | 1 | A beat accepted |
| aOpcode | input | 3 | 0 PutFull, 1 PutPartial, 4 Get |
| aSize | input | 3 | log2 of request bytes |
| aSource | input | ID_W | Requester tag |
| aAddr | input | ADDR_W | Byte address |
| aData | input | DATA_W | Write data for this beat |
| aMask | input | DATA_W/8 | Byte enables for this beat |
| arValid | output | 1 | Read address valid |
| arReady | input | 1 | Read address ready |
| arId | output | ID_W | Read id |
| arAddr | output | ADDR_W | Read address |
| arLen | output | 8 | Read beats minus one |
| arSize | output | 3 | Read beat size |
| awValid | output | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| awId | output | ID_W | Write id |
| awAddr | output | ADDR_W | Write address |
| awLen | output | 8 | Write beats minus one |
| awSize | output | 3 | Write beat size |
| wValid | output | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| wData | output | DATA_W | Write data |
| wStrb | output | DATA_W/8 | Write strobes |
| wLast | output | 1 | Final write beat |
| rValid | input | 1 | Read data valid |
| rReady | output | 1 | Read data taken |
| rId | input | ID_W | Read data id |
| rData | input | DATA_W | Read data |
| rResp | input | 2 | Read response code |
| rLast | input | 1 | Final read beat |
| bValid | input | 1 | Write response valid |
| bReady | output | 1 | Write response taken |
| bId | input | ID_W | Write response id |
| bResp | input | 2 | Write response code |
| dValid | output | 1 | D beat valid |
| dReady | input | 1 | D beat taken |
| dOpcode | output | 3 | 0 AccessAck, 1 AccessAckData |
| dSource | output | ID_W | Requester tag returned |
| dData | output | DATA_W | Read data, 0 for write acks |
| dDenied | output | 1 | Error response |

## Verification
The request side is tried with a single Get, a one-beat PutFull, a four-beat PutFull and a two-beat PutPartial. These separate how reads and writes are routed, and they show whether AW is sent once while W is sent on every beat. Back-pressure on AR, AW and W, together with stall, shows whether intake stops at the right time and whether queue order survives a full queue. On the response side, lone R and lone B with good and error codes check the encoding of D. Simultaneous R and B, a read burst with an idle gap, and a long stream of R beats against one waiting B separate plain R priority from burst holding and from the seven-cycle starvation limit.

// File: rtl/tl2axi_pkg.sv
package tl2axi_pkg;

  localparam logic [2:0] OP_PUT_FULL = 3'd0;
  localparam logic [2:0] OP_PUT_PART = 3'd1;
  localparam logic [2:0] OP_GET      = 3'd4;

  localparam logic [2:0] OP_ACK      = 3'd0;
  localparam logic [2:0] OP_ACK_DATA = 3'd1;

  localparam logic [2:0] B_WAIT_MAX  = 3'd7;

  typedef struct packed {
    logic qPush;   // enqueue an address entry this cycle
    logic qWrite;  // the entry being pushed is a write
    logic rWins;   // D channel carries R this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/tl2axi_ctrl.sv
module tl2axi_ctrl
  import tl2axi_pkg::*;
#(
  parameter int SIZE_W   = 3,
  parameter int BYTE_LOG = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic              aValid,
  input  logic [2:0]        aOpcode,
  input  logic [SIZE_W-1:0] aSize,
  input  logic              qReady,
  input  logic              wReady,
  input  logic              rValid,
  input  logic              rLast,
  input  logic              bValid,
  input  logic              dReady,
  output logic              aReady,
  output logic              wValid,
  output logic              wLast,
  output logic [7:0]        beatsM1,
  output logic              rReady,
  output logic              bReady,
  output logic              dValid,
  output ctrlStrobe_t       strobe
);

  logic       isPut, isGet, wFire, addrDone;
  logic [7:0] beatCnt;
  logic [2:0] bDelay;
  logic       rHolds;

  assign isPut = (aOpcode == OP_PUT_FULL) || (aOpcode == OP_PUT_PART);
  assign isGet = (aOpcode == OP_GET);

  always_comb begin
    beatsM1 = '0;
    if (aSize > SIZE_W'(BYTE_LOG))
      beatsM1 = 8'((9'd1 << (aSize - SIZE_W'(BYTE_LOG))) - 9'd1);
  end

  // Request side
  assign wLast  = (beatCnt == beatsM1);
  assign wValid = !stall && aValid && isPut && (addrDone || qReady);
  assign aReady = !stall && (isPut ? ((addrDone || qReady) && wReady)
                                   : (isGet && qReady));
  assign wFire  = wValid && wReady;

  assign strobe.qPush  = !stall && aValid && qReady &&
                         (isGet || (isPut && !addrDone && wReady));
  assign strobe.qWrite = isPut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt  <= '0;
      addrDone <= 1'b0;
    end else if (wFire) begin
      if (wLast) begin
        beatCnt  <= '0;
        addrDone <= 1'b0;
      end else begin
        beatCnt  <= beatCnt + 8'd1;
        addrDone <= 1'b1;
      end
    end
  end

  // Response side
  assign strobe.rWins = (rValid && bDelay != B_WAIT_MAX) || rHolds;
  assign rReady = dReady && strobe.rWins;
  assign bReady = dReady && !strobe.rWins;
  assign dValid = strobe.rWins ? rValid : bValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bDelay <= '0;
      rHolds <= 1'b0;
    end else begin
      if (bValid && bReady)                        bDelay <= '0;
      else if (bValid && bDelay != B_WAIT_MAX)     bDelay <= bDelay + 3'd1;
      if (rValid && rReady)                        rHolds <= !rLast;
    end
  end

  AST_ADDR_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (wValid && wReady && !wLast) |=> !strobe.qPush);                  // R3

  AST_HOLD_BURST: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rReady && !rLast) |=> !bReady);                        // R10

  AST_STARVE_WIN: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && dReady && !rHolds && bDelay == B_WAIT_MAX) |-> bReady); // R9

endmodule

// File: rtl/tl2axi_dp.sv
module tl2axi_dp
  import tl2axi_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int ID_W     = 4,
  parameter int SIZE_W   = 3,
  parameter int DEPTH    = 2,
  parameter int BYTE_LOG = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  output logic                qReady,
  input  logic [ID_W-1:0]     aSource,
  input  logic [ADDR_W-1:0]   aAddr,
  input  logic [SIZE_W-1:0]   aSize,
  input  logic [7:0]          axLen,
  input  logic [DATA_W-1:0]   aData,
  input  logic [DATA_W/8-1:0] aMask,
  output logic                arValid,
  input  logic                arReady,
  output logic [ID_W-1:0]     arId,
  output logic [ADDR_W-1:0]   arAddr,
  output logic [7:0]          arLen,
  output logic [2:0]          arSize,
  output logic                awValid,
  input  logic                awReady,
  output logic [ID_W-1:0]     awId,
  output logic [ADDR_W-1:0]   awAddr,
  output logic [7:0]          awLen,
  output logic [2:0]          awSize,
  output logic [DATA_W-1:0]   wData,
  output logic [DATA_W/8-1:0] wStrb,
  input  logic [ID_W-1:0]     rId,
  input  logic [DATA_W-1:0]   rData,
  input  logic [1:0]          rResp,
  input  logic [ID_W-1:0]     bId,
  input  logic [1:0]          bResp,
  output logic [2:0]          dOpcode,
  output logic [ID_W-1:0]     dSource,
  output logic [DATA_W-1:0]   dData,
  output logic                dDenied
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic              wen;
    logic [ID_W-1:0]   id;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        len;
    logic [2:0]        size;
  } addrEnt_t;

  addrEnt_t   slots [DEPTH];
  addrEnt_t   newEnt, head;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic       notEmpty, pop;

  assign newEnt.wen  = strobe.qWrite;
  assign newEnt.id   = aSource;
  assign newEnt.addr = aAddr;
  assign newEnt.len  = axLen;
  assign newEnt.size = (aSize > SIZE_W'(BYTE_LOG)) ? 3'(BYTE_LOG) : 3'(aSize);

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strobe.qPush && wrPtr == PTR_W'(g)) slots[g] <= newEnt;
    end
  end

  assign head     = slots[rdPtr];
  assign notEmpty = (count != '0);
  assign qReady   = (count < CNT_W'(DEPTH));
  assign pop      = notEmpty && (head.wen ? awReady : arReady);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.qPush)
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (pop)
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      count <= count + CNT_W'(strobe.qPush) - CNT_W'(pop);
    end
  end

  assign arValid = notEmpty && !head.wen;
  assign awValid = notEmpty &&  head.wen;
  assign arId = head.id;  assign arAddr = head.addr;
  assign arLen = head.len; assign arSize = head.size;
  assign awId = head.id;  assign awAddr = head.addr;
  assign awLen = head.len; assign awSize = head.size;

  assign wData = aData;
  assign wStrb = aMask;

  assign dOpcode = strobe.rWins ? OP_ACK_DATA : OP_ACK;
  assign dSource = strobe.rWins ? rId : bId;
  assign dData   = strobe.rWins ? rData : '0;
  assign dDenied = strobe.rWins ? (rResp != 2'b00) : (bResp != 2'b00);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.qPush |-> (count < CNT_W'(DEPTH)));                        // R5

  AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && !arReady) |=> (arValid && $stable(arAddr)));          // R1

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && !awReady) |=> (awValid && $stable(awAddr)));          // R2

endmodule

// File: rtl/tl2axi_bridge.sv
module tl2axi_bridge
  import tl2axi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int SIZE_W = 3,
  parameter int QDEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stall,
  input  logic                aValid,
  output logic                aReady,
  input  logic [2:0]          aOpcode,
  input  logic [SIZE_W-1:0]   aSize,
  input  logic [ID_W-1:0]     aSource,
  input  logic [ADDR_W-1:0]   aAddr,
  input  logic [DATA_W-1:0]   aData,
  input  logic [DATA_W/8-1:0] aMask,
  output logic                arValid,
  input  logic                arReady,
  output logic [ID_W-1:0]     arId,
  output logic [ADDR_W-1:0]   arAddr,
  output logic [7:0]          arLen,
  output logic [2:0]          arSize,
  output logic                awValid,
  input  logic                awReady,
  output logic [ID_W-1:0]     awId,
  output logic [ADDR_W-1:0]   awAddr,
  output logic [7:0]          awLen,
  output logic [2:0]          awSize,
  output logic                wValid,
  input  logic                wReady,
  output logic [DATA_W-1:0]   wData,
  output logic [DATA_W/8-1:0] wStrb,
  output logic                wLast,
  input  logic                rValid,
  output logic                rReady,
  input  logic [ID_W-1:0]     rId,
  input  logic [DATA_W-1:0]   rData,
  input  logic [1:0]          rResp,
  input  logic                rLast,
  input  logic                bValid,
  output logic                bReady,
  input  logic [ID_W-1:0]     bId,
  input  logic [1:0]          bResp,
  output logic                dValid,
  input  logic                dReady,
  output logic [2:0]          dOpcode,
  output logic [ID_W-1:0]     dSource,
  output logic [DATA_W-1:0]   dData,
  output logic                dDenied
);

  localparam int BYTE_LOG = $clog2(DATA_W / 8);

  ctrlStrobe_t strobe;
  logic        qReady;
  logic [7:0]  beatsM1;

  tl2axi_ctrl #(.SIZE_W(SIZE_W), .BYTE_LOG(BYTE_LOG)) u_ctrl (
    .clk(clk), .rstN(rstN), .stall(stall),
    .aValid(aValid), .aOpcode(aOpcode), .aSize(aSize),
    .qReady(qReady), .wReady(wReady),
    .rValid(rValid), .rLast(rLast), .bValid(bValid), .dReady(dReady),
    .aReady(aReady), .wValid(wValid), .wLast(wLast), .beatsM1(beatsM1),
    .rReady(rReady), .bReady(bReady), .dValid(dValid), .strobe(strobe)
  );

  tl2axi_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .SIZE_W(SIZE_W),
    .DEPTH(QDEPTH), .BYTE_LOG(BYTE_LOG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .qReady(qReady),
    .aSource(aSource), .aAddr(aAddr), .aSize(aSize), .axLen(beatsM1),
    .aData(aData), .aMask(aMask),
    .arValid(arValid), .arReady(arReady), .arId(arId), .arAddr(arAddr),
    .arLen(arLen), .arSize(arSize),
    .awValid(awValid), .awReady(awReady), .awId(awId), .awAddr(awAddr),
    .awLen(awLen), .awSize(awSize),
    .wData(wData), .wStrb(wStrb),
    .rId(rId), .rData(rData), .rResp(rResp), .bId(bId), .bResp(bResp),
    .dOpcode(dOpcode), .dSource(dSource), .dData(dData), .dDenied(dDenied)
  );

endmodule

// File: tb/tl2axi_bridge_tb.sv
`timescale 1ns/1ps
module tl2axi_bridge_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, stall = 1'b0;
  logic aValid = 1'b0, aReady;
  logic [2:0] aOpcode = 3'd4, aSize = 3'd2;
  logic [3:0] aSource = '0;
  logic [31:0] aAddr = '0, aData = '0;
  logic [3:0] aMask = '0;
  logic arValid, arReady = 1'b1; logic [3:0] arId; logic [31:0] arAddr; logic [7:0] arLen; logic [2:0] arSize;
  logic awValid, awReady = 1'b1; logic [3:0] awId; logic [31:0] awAddr; logic [7:0] awLen; logic [2:0] awSize;
  logic wValid, wReady = 1'b1, wLast; logic [31:0] wData; logic [3:0] wStrb;
  logic rValid = 1'b0, rReady, rLast = 1'b0; logic [3:0] rId = '0; logic [31:0] rData = '0; logic [1:0] rResp = '0;
  logic bValid = 1'b0, bReady; logic [3:0] bId = '0; logic [1:0] bResp = '0;
  logic dValid, dReady = 1'b1, dDenied; logic [2:0] dOpcode; logic [3:0] dSource; logic [31:0] dData;

  tl2axi_bridge u_dut (.*);

  int checks = 0, errors = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Scoreboard queues
  logic [46:0] expAr[$], expAw[$];
  logic [36:0] expW[$];
  logic [39:0] expD[$];
  logic [38:0] rSrc[$];   // {id, data, resp, last}
  logic [5:0]  bSrc[$];   // {id, resp}
  logic rTake = 1'b0, bTake = 1'b0;

  // Monitor: samples in mid-cycle
  initial forever begin
    @(negedge clk);
    if (rstN) begin
      if (arValid && arReady) begin
        if (expAr.size() == 0) chk("R1", "unexpected AR", 64'(arAddr), 64'h0);
        else chk("R1", "AR fields", 64'({arId, arAddr, arLen, arSize}), 64'(expAr.pop_front()));
      end
      if (awValid && awReady) begin
        if (expAw.size() == 0) chk("R2", "unexpected AW", 64'(awAddr), 64'h0);
        else chk("R2", "AW fields", 64'({awId, awAddr, awLen, awSize}), 64'(expAw.pop_front()));
      end
      if (wValid && wReady) begin
        if (expW.size() == 0) chk("R3", "unexpected W", 64'(wData), 64'h0);
        else chk("R3", "W beat", 64'({wData, wStrb, wLast}), 64'(expW.pop_front()));
      end
      if (dValid && dReady) begin
        if (expD.size() == 0) chk("R7", "unexpected D", 64'(dSource), 64'h0);
        else chk("R8", "D beat order/fields (R7 R9 R10)",
                 64'({dOpcode, dSource, dData, dDenied}), 64'(expD.pop_front()));
      end
      if (rValid && rReady) rTake = 1'b1;
      if (bValid && bReady) bTake = 1'b1;
    end
  end

  // AXI response sources
  initial forever begin
    @(posedge clk); #2;
    if (rTake) begin void'(rSrc.pop_front()); rTake = 1'b0; end
    if (bTake) begin void'(bSrc.pop_front()); bTake = 1'b0; end
    rValid = (rSrc.size() != 0);
    if (rValid) {rId, rData, rResp, rLast} = rSrc[0];
    bValid = (bSrc.size() != 0);
    if (bValid) {bId, bResp} = bSrc[0];
  end

  task automatic driveA(input logic [2:0] op, input logic [2:0] sz, input logic [3:0] src,
                        input logic [31:0] addr, input logic [31:0] data, input logic [3:0] mask);
    aValid = 1'b1; aOpcode = op; aSize = sz; aSource = src;
    aAddr = addr; aData = data; aMask = mask;
  endtask

  task automatic waitAccept();
    @(negedge clk);
    while (!aReady) @(negedge clk);
    @(posedge clk); #1;
    aValid = 1'b0;
  endtask

  function automatic logic [7:0] lenOf(input logic [2:0] sz);
    return (sz > 3'd2) ? 8'((1 << (sz - 3'd2)) - 1) : 8'd0;
  endfunction

  function automatic logic [2:0] axSz(input logic [2:0] sz);
    return (sz > 3'd2) ? 3'd2 : sz;
  endfunction

  task automatic getReq(input logic [2:0] sz, input logic [3:0] src, input logic [31:0] addr);
    expAr.push_back({src, addr, lenOf(sz), axSz(sz)});
    driveA(3'd4, sz, src, addr, 32'h0, 4'h0);
    waitAccept();
  endtask

  task automatic putReq(input logic [2:0] op, input logic [2:0] sz, input logic [3:0] src,
                        input logic [31:0] addr, input logic [31:0] base, input logic [3:0] mask);
    logic [7:0] n = lenOf(sz);
    expAw.push_back({src, addr, n, axSz(sz)});
    for (int i = 0; i <= int'(n); i++) begin
      expW.push_back({base + 32'(i), mask, (i == int'(n))});
      driveA(op, sz, src, addr, base + 32'(i), mask);
      waitAccept();
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      if (expAr.size() == 0 && expAw.size() == 0 && expW.size() == 0 &&
          expD.size() == 0 && rSrc.size() == 0 && bSrc.size() == 0) break;
      @(posedge clk); #1;
    end
    repeat (2) @(posedge clk); #1;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "arValid", 64'(arValid), 64'd0);
    chk("R11", "awValid", 64'(awValid), 64'd0);
    chk("R11", "wValid",  64'(wValid),  64'd0);
    chk("R11", "dValid",  64'(dValid),  64'd0);
    chk("R11", "aReady",  64'(aReady),  64'd1);
    @(posedge clk); #1;

    // R1 single-beat and burst Get
    getReq(3'd2, 4'd3, 32'h0000_1000);
    getReq(3'd4, 4'd9, 32'h0000_2040);
    // R2 single-beat PutFull
    putReq(3'd0, 3'd2, 4'd5, 32'h0000_3000, 32'hA5A5_0000, 4'hF);
    // R3 four-beat PutFull and two-beat PutPartial
    putReq(3'd0, 3'd4, 4'd6, 32'h0000_4000, 32'h1111_0000, 4'hF);
    putReq(3'd1, 3'd3, 4'd7, 32'h0000_5000, 32'h2222_0000, 4'h3);
    drain();

    // R5 full queue blocks a third request, order kept
    arReady = 1'b0;
    getReq(3'd2, 4'd1, 32'h100);
    getReq(3'd2, 4'd2, 32'h200);
    expAr.push_back({4'd3, 32'h300, 8'd0, 3'd2});
    driveA(3'd4, 3'd2, 4'd3, 32'h300, 32'h0, 4'h0);
    repeat (3) begin @(negedge clk); chk("R5", "aReady while full", 64'(aReady), 64'd0); end
    @(posedge clk); #1; arReady = 1'b1;
    waitAccept();
    drain();

    // R6 stall blocks intake
    stall = 1'b1;
    driveA(3'd4, 3'd2, 4'd4, 32'h400, 32'h0, 4'h0);
    repeat (3) begin
      @(negedge clk);
      chk("R6", "aReady under stall", 64'(aReady), 64'd0);
      chk("R6", "no AR under stall", 64'(arValid), 64'd0);
    end
    @(posedge clk); #1; stall = 1'b0;
    expAr.push_back({4'd4, 32'h400, 8'd0, 3'd2});
    waitAccept();
    drain();

    // R4 W not ready: no beat, no address
    wReady = 1'b0;
    expAw.push_back({4'd8, 32'h800, 8'd0, 3'd2});
    expW.push_back({32'hBEEF_0001, 4'hF, 1'b1});
    driveA(3'd0, 3'd2, 4'd8, 32'h800, 32'hBEEF_0001, 4'hF);
    repeat (3) begin
      @(negedge clk);
      chk("R4", "aReady without W ready", 64'(aReady), 64'd0);
      chk("R4", "no AW without W ready", 64'(awValid), 64'd0);
    end
    @(posedge clk); #1; wReady = 1'b1;
    waitAccept();
    drain();

    // R4 queue full with writes: W must not start
    awReady = 1'b0;
    putReq(3'd0, 3'd2, 4'd1, 32'h900, 32'hC0DE_0001, 4'hF);
    putReq(3'd0, 3'd2, 4'd2, 32'hA00, 32'hC0DE_0002, 4'hF);
    expAw.push_back({4'd3, 32'hB00, 8'd0, 3'd2});
    expW.push_back({32'hC0DE_0003, 4'hF, 1'b1});
    driveA(3'd0, 3'd2, 4'd3, 32'hB00, 32'hC0DE_0003, 4'hF);
    repeat (2) begin
      @(negedge clk);
      chk("R4", "wValid while queue full", 64'(wValid), 64'd0);
      chk("R5", "aReady while queue full", 64'(aReady), 64'd0);
    end
    @(posedge clk); #1; awReady = 1'b1;
    waitAccept();
    drain();

    // R7 / R8 response encoding
    expD.push_back({3'd1, 4'd5, 32'h1234_5678, 1'b0});
    rSrc.push_back({4'd5, 32'h1234_5678, 2'd0, 1'b1});
    drain();
    expD.push_back({3'd1, 4'd6, 32'h0BAD_0BAD, 1'b1});
    rSrc.push_back({4'd6, 32'h0BAD_0BAD, 2'd2, 1'b1});
    drain();
    expD.push_back({3'd0, 4'd7, 32'h0, 1'b0});
    bSrc.push_back({4'd7, 2'd0});
    drain();
    expD.push_back({3'd0, 4'd8, 32'h0, 1'b1});
    bSrc.push_back({4'd8, 2'd3});
    drain();

    // R7 R preferred when both arrive together
    expD.push_back({3'd1, 4'd2, 32'h0000_00AA, 1'b0});
    expD.push_back({3'd0, 4'd3, 32'h0, 1'b0});
    rSrc.push_back({4'd2, 32'h0000_00AA, 2'd0, 1'b1});
    bSrc.push_back({4'd3, 2'd0});
    drain();

    // R10 a started R burst keeps D through an idle gap
    expD.push_back({3'd1, 4'd4, 32'h0000_0001, 1'b0});
    rSrc.push_back({4'd4, 32'h0000_0001, 2'd0, 1'b0});
    bSrc.push_back({4'd9, 2'd0});
    @(negedge clk);
    @(posedge clk); #1;
    repeat (3) begin
      @(negedge clk);
      chk("R10", "bReady during burst gap", 64'(bReady), 64'd0);
      chk("R10", "dValid during burst gap", 64'(dValid), 64'd0);
    end
    @(posedge clk); #1;
    expD.push_back({3'd1, 4'd4, 32'h0000_0002, 1'b0});
    expD.push_back({3'd0, 4'd9, 32'h0, 1'b0});
    rSrc.push_back({4'd4, 32'h0000_0002, 2'd0, 1'b1});
    drain();

    // R9 starved B wins after seven R grants
    for (int i = 0; i < 10; i++) rSrc.push_back({4'd1, 32'(i), 2'd0, 1'b1});
    bSrc.push_back({4'd2, 2'd0});
    for (int i = 0; i < 7; i++) expD.push_back({3'd1, 4'd1, 32'(i), 1'b0});
    expD.push_back({3'd0, 4'd2, 32'h0, 1'b0});
    for (int i = 7; i < 10; i++) expD.push_back({3'd1, 4'd1, 32'(i), 1'b0});
    drain();

    chk("R2", "AR/AW expectations left", 64'(expAr.size() + expAw.size()), 64'd0);
    chk("R3", "W expectations left", 64'(expW.size()), 64'd0);
    chk("R9", "D expectations left", 64'(expD.size()), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule